// File: doc/BRIEF.md
# Stereo Digital Volume Ramper

This block scales two channels of 24-bit two's-complement audio by a per-channel attenuation. Each channel has an 8-bit attenuation code and a mute request. It keeps an internal level in steps of 1/8 dB. That level follows the target in one of four ways: it can jump at once, wait for a signal zero crossing, ramp softly, or wait for a zero crossing and then ramp. The level is turned into a linear gain with a 48-entry fractional table and an arithmetic shift, and the gain is applied with a multiply.

Samples arrive with a one-cycle strobe. Each strobe advances the level controllers by one sample period and produces one registered output pair. A single-volume option lets the channel A code set both channels. Each channel can also have its polarity inverted.

Top module: `vr_stereo_ramper`

## Requirements
- R1: An attenuation code c maps to a level L = 4·c eighths of a dB. Bits 7:1 of the code are whole dB and bit 0 adds 0.5 dB, so the range is 0 to 127.5 dB. A level L below 1024 scales a sample x to x·2^(−L/48): 48 eighths make one halving. The result is within 0.2 % + 2 LSB of that value.
- R2: In reset, out_a, out_b and out_valid are 0 and both levels are 0 dB. Each output is registered, and out_valid is high exactly in the cycle after an in_valid cycle. Sample n is scaled by the level held before strobe n. A level adopted at strobe n applies from sample n+1, and levels change only on strobes.
- R3: With xfade_mode = 2'b00 (immediate), the level becomes the target at the next strobe.
- R4: With xfade_mode = 2'b01 (zero-cross), a pending change is adopted at a strobe whose sample is exactly 0 or whose sign bit differs from the previous sample of that channel.
- R5: In zero-cross mode, a change that has seen no crossing is forced through on its 1024th pending strobe.
- R6: With xfade_mode = 2'b10 (soft), the level moves one 1/8 dB step toward the target on every strobe, which is 1 dB per 8 samples.
- R7: With xfade_mode = 2'b11, a ramp toward a new target starts at a zero crossing or at the 1024-strobe timeout. After that it steps on every strobe without waiting again.
- R8: Zero-crossing detection and the timeout counter are separate for each channel.
- R9: When single_vol = 1, channel B takes its target from att_a and att_b has no effect.
- R10: A mute request sets the target to level 1024. It follows the selected mode like any other change, and once level 1024 is reached the output is exactly 0.
- R11: When invert_x = 1, channel x's samples are negated before scaling, and −2^23 saturates to 2^23−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample pair |
| in_a | input | 24 | Channel A sample, two's complement |
| in_b | input | 24 | Channel B sample, two's complement |
| att_a | input | 8 | Channel A attenuation code |
| att_b | input | 8 | Channel B attenuation code |
| mute_a | input | 1 | Channel A mute request |
| mute_b | input | 1 | Channel B mute request |
| xfade_mode | input | 2 | Transition mode: 00 immediate, 01 zero-cross, 10 soft, 11 soft after zero-cross |
| single_vol | input | 1 | Use att_a for both channels |
| invert_a | input | 1 | Negate channel A |
| invert_b | input | 1 | Negate channel B |
| out_valid | output | 1 | Output pair valid |
| out_a | output | 24 | Scaled channel A sample |
| out_b | output | 24 | Scaled channel B sample |

## Verification
The bench checks the one-sample lag between adopting a level and hearing it. A design that applied new levels to the current sample would fail the first-strobe checks in every mode. It runs the zero-cross timeout to the exact 1024th strobe and sends a crossing on one channel only. An off-by-one counter, or a detector shared between channels, would release a change early, late or on the wrong channel. It also checks a soft ramp at its midpoint and at its end, a ramp that starts at a crossing and then continues freely, negation of the most negative sample, and a mute ramp that must end in exact zeros rather than a tiny residue.

// File: rtl/vr_pkg.sv
package vr_pkg;

    localparam int SAMPLE_W          = 24;
    localparam int ATT_W             = 8;
    localparam int CODE_SHIFT        = 2;   // one code LSB = 0.5 dB = 4 eighths
    localparam int STEPS_PER_HALVING = 48;  // 6 dB per halving, in eighths
    localparam int FRAC_W            = 16;
    localparam int MUTE_LVL          = (1 << (ATT_W + CODE_SHIFT));
    localparam int LVL_W             = $clog2(MUTE_LVL + 1);
    localparam int ZC_TIMEOUT        = 1024;

    // 2^(-1/48) in Q30
    localparam logic [63:0] STEP_RATIO_Q30 = 64'd1058347792;

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [1:0] {
        XF_IMMEDIATE = 2'b00,
        XF_ZEROCROSS = 2'b01,
        XF_SOFT      = 2'b10,
        XF_SOFT_ZC   = 2'b11
    } xfade_e;

    // Q(FRAC_W) value of 2^(-k/48), built by repeated multiplication
    function automatic logic [FRAC_W:0] frac_gain(input int k);
        logic [63:0] acc;
        acc = 64'd1 << 30;
        for (int i = 0; i < k; i++) begin
            acc = (acc * STEP_RATIO_Q30) >> 30;
        end
        return (FRAC_W+1)'(acc >> (30 - FRAC_W));
    endfunction

endpackage

// File: rtl/vr_level_ctrl.sv
module vr_level_ctrl
    import vr_pkg::*;
#(
    parameter int SMP_W   = SAMPLE_W,
    parameter int TIMEOUT = ZC_TIMEOUT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [SMP_W-1:0] sample,
    input  level_t           target,
    input  xfade_e           mode,
    output level_t           level
);

    localparam int TMR_W = $clog2(TIMEOUT);

    level_t           lvl_q, lvl_d, stepped;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             ramp_q, ramp_d;
    logic             prev_sign_q;
    logic             crossing, expired, pending;

    always_comb begin
        crossing = (sample[SMP_W-1] != prev_sign_q) || (sample == '0);
        expired  = (tmr_q == TMR_W'(TIMEOUT - 1));
        pending  = (lvl_q != target);
        stepped  = (target > lvl_q) ? lvl_q + level_t'(1) : lvl_q - level_t'(1);
        lvl_d    = lvl_q;
        tmr_d    = tmr_q;
        ramp_d   = ramp_q;
        if (!pending) begin
            tmr_d  = '0;
            ramp_d = 1'b0;
        end else begin
            unique case (mode)
                XF_IMMEDIATE: begin
                    lvl_d = target;
                    tmr_d = '0;
                end
                XF_ZEROCROSS: begin
                    if (crossing || expired) begin
                        lvl_d = target;
                        tmr_d = '0;
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                XF_SOFT: begin
                    lvl_d = stepped;
                    tmr_d = '0;
                end
                XF_SOFT_ZC: begin
                    if (ramp_q || crossing || expired) begin
                        lvl_d  = stepped;
                        ramp_d = (stepped != target);
                        tmr_d  = '0;
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                default: lvl_d = lvl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q       <= '0;
            tmr_q       <= '0;
            ramp_q      <= 1'b0;
            prev_sign_q <= 1'b0;
        end else if (strobe) begin
            lvl_q       <= lvl_d;
            tmr_q       <= tmr_d;
            ramp_q      <= ramp_d;
            prev_sign_q <= sample[SMP_W-1];
        end
    end

    assign level = lvl_q;

    assert_level_range_R10: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= level_t'(MUTE_LVL));

    assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(strobe)) |-> $stable(lvl_q));

    assert_immediate_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(strobe) && $past(mode) == XF_IMMEDIATE) |-> lvl_q == $past(target));

    assert_soft_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(strobe) && $past(mode) == XF_SOFT) |->
            (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + level_t'(1)
             || lvl_q == $past(lvl_q) - level_t'(1)));

    assert_timeout_forces_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(strobe) && $past(mode) == XF_ZEROCROSS && $past(expired))
            |-> lvl_q == $past(target));

endmodule

// File: rtl/vr_gain_apply.sv
module vr_gain_apply
    import vr_pkg::*;
#(
    parameter int SMP_W = SAMPLE_W
) (
    input  logic [SMP_W-1:0] sample,
    input  logic             invert,
    input  level_t           level,
    output logic [SMP_W-1:0] scaled
);

    localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic [SMP_W-1:0] MOST_POS = ~MOST_NEG;
    localparam int OCT_W  = $clog2(MUTE_LVL / STEPS_PER_HALVING + 1);
    localparam int FR_W   = $clog2(STEPS_PER_HALVING);
    localparam int PROD_W = SMP_W + FRAC_W + 2;

    logic [FRAC_W:0] frac_tab [STEPS_PER_HALVING];

    for (genvar k = 0; k < STEPS_PER_HALVING; k++) begin : g_frac
        assign frac_tab[k] = frac_gain(k);
    end

    logic [SMP_W-1:0]          oriented;
    logic [OCT_W-1:0]          oct;
    logic [FR_W-1:0]           fr;
    logic signed [PROD_W-1:0]  smp_ext, gain_ext, prod, shifted;

    always_comb begin
        if (invert) begin
            oriented = (sample == MOST_NEG) ? MOST_POS : (~sample + 1'b1);
        end else begin
            oriented = sample;
        end
        oct      = OCT_W'(level / level_t'(STEPS_PER_HALVING));
        fr       = FR_W'(level % level_t'(STEPS_PER_HALVING));
        smp_ext  = PROD_W'($signed(oriented));
        gain_ext = PROD_W'({1'b0, frac_tab[fr]});
        prod     = smp_ext * gain_ext;
        shifted  = prod >>> (FRAC_W + int'(oct));
        scaled   = (level >= level_t'(MUTE_LVL)) ? '0 : shifted[SMP_W-1:0];
    end

endmodule

// File: rtl/vr_stereo_ramper.sv
module vr_stereo_ramper
    import vr_pkg::*;
#(
    parameter int SMP_W   = SAMPLE_W,
    parameter int TIMEOUT = ZC_TIMEOUT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_a,
    input  logic [SMP_W-1:0] in_b,
    input  logic [ATT_W-1:0] att_a,
    input  logic [ATT_W-1:0] att_b,
    input  logic             mute_a,
    input  logic             mute_b,
    input  logic [1:0]       xfade_mode,
    input  logic             single_vol,
    input  logic             invert_a,
    input  logic             invert_b,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_a,
    output logic [SMP_W-1:0] out_b
);

    localparam int NCH = 2;

    logic [SMP_W-1:0] smp    [NCH];
    logic [ATT_W-1:0] code   [NCH];
    logic             mute   [NCH];
    logic             inv    [NCH];
    level_t           tgt    [NCH];
    level_t           lvl    [NCH];
    logic [SMP_W-1:0] gained [NCH];
    logic [SMP_W-1:0] res_q  [NCH];
    xfade_e           mode;
    logic             valid_q;

    assign mode    = xfade_e'(xfade_mode);
    assign smp[0]  = in_a;
    assign smp[1]  = in_b;
    assign code[0] = att_a;
    assign code[1] = single_vol ? att_a : att_b;
    assign mute[0] = mute_a;
    assign mute[1] = mute_b;
    assign inv[0]  = invert_a;
    assign inv[1]  = invert_b;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign tgt[c] = mute[c] ? level_t'(MUTE_LVL) : (level_t'(code[c]) << CODE_SHIFT);

        vr_level_ctrl #(.SMP_W(SMP_W), .TIMEOUT(TIMEOUT)) level_i (
            .clk    (clk),
            .rst    (rst),
            .strobe (in_valid),
            .sample (smp[c]),
            .target (tgt[c]),
            .mode   (mode),
            .level  (lvl[c])
        );

        vr_gain_apply #(.SMP_W(SMP_W)) gain_i (
            .sample (smp[c]),
            .invert (inv[c]),
            .level  (lvl[c]),
            .scaled (gained[c])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q[c] <= '0;
            end else if (in_valid) begin
                res_q[c] <= gained[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= in_valid;
    end

    assign out_valid = valid_q;
    assign out_a     = res_q[0];
    assign out_b     = res_q[1];

    assert_valid_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_mute_silent_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst) && $past(lvl[0]) == level_t'(MUTE_LVL)) |-> out_a == '0);

endmodule

// File: tb/vr_stereo_ramper_tb.sv
module vr_stereo_ramper_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [23:0] in_a, in_b;
    logic [7:0]  att_a, att_b;
    logic        mute_a, mute_b;
    logic [1:0]  xfade_mode;
    logic        single_vol, invert_a, invert_b;
    logic        out_valid;
    logic [23:0] out_a, out_b;

    int errors = 0;
    int checks = 0;
    int got_a, got_b;
    logic got_v;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vr_stereo_ramper dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .att_a(att_a), .att_b(att_b), .mute_a(mute_a), .mute_b(mute_b),
        .xfade_mode(xfade_mode), .single_vol(single_vol),
        .invert_a(invert_a), .invert_b(invert_b),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected value of x scaled by level L (eighths of a dB)
    task automatic check_lvl(input string tag, input int act, input int x, input int lvl);
        real r, tol, d;
        checks++;
        if (lvl >= 1024) begin
            r = 0.0;
            tol = 0.0;
        end else begin
            r = real'(x) * (2.0 ** (-real'(lvl) / 48.0));
            tol = ((r < 0.0) ? -r : r) * 0.002 + 2.0;
        end
        d = real'(act) - r;
        if (d < 0.0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0f", tag, act, r);
        end
    endtask

    task automatic push(input int a, input int b);
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a[23:0];
        in_b = b[23:0];
        @(negedge clk);
        in_valid = 1'b0;
        got_a = int'($signed(out_a));
        got_b = int'($signed(out_b));
        got_v = out_valid;
    endtask

    task automatic t_reset;
        check_eq("R2 reset out_a", int'($signed(out_a)), 0);
        check_eq("R2 reset out_b", int'($signed(out_b)), 0);
        check_eq("R2 reset out_valid", int'(out_valid), 0);
    endtask

    task automatic t_immediate;
        xfade_mode = 2'b00;
        att_a = 8'h14;  // 10 dB -> L=80
        att_b = 8'h01;  // 0.5 dB -> L=4
        push(1000000, -3000000);
        check_lvl("R2 first sample keeps old level A", got_a, 1000000, 0);
        check_eq("R2 out_valid after strobe", int'(got_v), 1);
        @(negedge clk);
        check_eq("R2 out_valid drops", int'(out_valid), 0);
        push(1000000, -3000000);
        check_lvl("R3 immediate A 10 dB", got_a, 1000000, 80);
        check_lvl("R1 half-dB code B", got_b, -3000000, 4);
        att_a = 8'hFF;  // 127.5 dB
        att_b = 8'h0C;  // 6 dB
        push(8388607, 7000000);
        push(8388607, 7000000);
        check_lvl("R1 full-scale code A", got_a, 8388607, 1020);
        check_lvl("R1 six dB halves B", got_b, 7000000, 48);
    endtask

    task automatic t_invert;
        att_a = 8'h00;
        att_b = 8'h00;
        invert_a = 1'b1;
        invert_b = 1'b1;
        push(-8388608, 5);
        push(-8388608, 5);
        check_eq("R11 most negative saturates", got_a, 8388607);
        check_eq("R11 negate B", got_b, -5);
        invert_a = 1'b0;
        invert_b = 1'b0;
    endtask

    task automatic t_mute_immediate;
        mute_a = 1'b1;
        push(8000000, 8000000);
        push(8000000, 8000000);
        check_eq("R10 immediate mute A zero", got_a, 0);
        check_eq("R10 B unaffected", got_b, 8000000);
        mute_a = 1'b0;
        push(8000000, 8000000);
        push(8000000, 8000000);
        check_eq("R10 unmute restores A", got_a, 8000000);
    endtask

    task automatic t_single;
        single_vol = 1'b1;
        att_a = 8'h0C;
        att_b = 8'h00;
        push(600000, 600000);
        push(600000, 600000);
        check_lvl("R9 B follows att_a", got_b, 600000, 48);
        check_lvl("R9 A own code", got_a, 600000, 48);
        single_vol = 1'b0;
        att_a = 8'h00;
        push(600000, 600000);
        push(600000, 600000);
    endtask

    task automatic t_zero_cross;
        xfade_mode = 2'b01;
        att_a = 8'h0C;
        att_b = 8'h0C;
        for (int i = 0; i < 5; i++) push(400000, 400000);
        check_eq("R4 no crossing holds A", got_a, 400000);
        push(-200000, 400000);
        check_eq("R4 crossing sample keeps old level", got_a, -200000);
        push(400000, 400000);
        check_lvl("R4 crossing adopted A", got_a, 400000, 48);
        check_eq("R8 B still waiting", got_b, 400000);
        push(400000, 0);
        push(400000, 400000);
        check_lvl("R4 zero sample adopted B", got_b, 400000, 48);
    endtask

    task automatic t_timeout;
        att_a = 8'h00;
        push(300000, 300000);
        check_lvl("R5 pending strobe 1 old level", got_a, 300000, 48);
        for (int i = 2; i <= 1024; i++) push(300000, 300000);
        check_lvl("R5 strobe 1024 old level", got_a, 300000, 48);
        push(300000, 300000);
        check_eq("R5 forced after timeout", got_a, 300000);
        check_lvl("R8 B level untouched", got_b, 300000, 48);
    endtask

    task automatic t_soft;
        xfade_mode = 2'b10;
        att_a = 8'h14;
        for (int i = 1; i <= 41; i++) push(1000000, 1000000);
        check_lvl("R6 ramp midpoint", got_a, 1000000, 40);
        for (int i = 42; i <= 81; i++) push(1000000, 1000000);
        check_lvl("R6 ramp reaches target", got_a, 1000000, 80);
        for (int i = 82; i <= 90; i++) push(1000000, 1000000);
        check_lvl("R6 ramp stays at target", got_a, 1000000, 80);
    endtask

    task automatic t_soft_zc;
        xfade_mode = 2'b11;
        att_a = 8'h00;
        for (int i = 0; i < 5; i++) push(1000000, 1000000);
        check_lvl("R7 waits for crossing", got_a, 1000000, 80);
        push(-1000000, 1000000);
        check_lvl("R7 crossing sample old level", got_a, -1000000, 80);
        for (int i = 0; i < 10; i++) push(1000000, 1000000);
        check_lvl("R7 ramp runs freely", got_a, 1000000, 70);
    endtask

    task automatic t_mute_soft;
        xfade_mode = 2'b10;
        mute_b = 1'b1;
        push(8388607, 8388607);
        check_lvl("R10 soft mute starts at old level", got_b, 8388607, 48);
        for (int i = 2; i <= 1000; i++) push(8388607, 8388607);
        check_eq("R10 soft mute ends at exact zero", got_b, 0);
        mute_b = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_a = '0;
        in_b = '0;
        att_a = '0;
        att_b = '0;
        mute_a = 1'b0;
        mute_b = 1'b0;
        xfade_mode = 2'b00;
        single_vol = 1'b0;
        invert_a = 1'b0;
        invert_b = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_invert();
        t_mute_immediate();
        t_single();
        t_zero_cross();
        t_timeout();
        t_soft();
        t_soft_zc();
        t_mute_soft();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule